// File: doc/BRIEF.md
# System Register Access Unit

This unit serves the move-to and move-from system-register operations of a small 32-bit core. A request names a 16-bit register address, made of a 5-bit group in the upper bits and an 11-bit index below it. The unit holds the core's system state locally: the exception vector base, the status word, the saved exception PC, address and status, a 64-bit multiply-accumulate register seen as two 32-bit halves, banks of shadow general-purpose registers, the floating-point control/status word and the power-management word. It also answers a set of fixed identification registers.

Privilege comes from bit 0 of the status word. While that bit is clear, only the floating-point control/status word may be touched; any other access is refused with an illegal-instruction flag and changes nothing. Address-translation, interrupt-controller and timer groups live in other blocks. For those the unit raises a one-hot select strobe and returns the data that the selected block drives back. A read of an address that no register implements returns the old destination value, so the register file keeps its contents. Writes to the next-PC and power-management registers drive a PC-load port, and a doze or sleep request halts the core.

Top module: `spr_unit`

## Requirements
- R1: After reset the status word reads 0x00000001 (supervisor mode), every other writable register reads zero, `halt` is low and `rsp_valid` is low.
- R2: The floating-point control/status register (group 0, index 20, address 0x0014) is readable and writable in both privilege modes, and it keeps only its low 12 bits.
- R3: While status bit 0 is clear, any other request sets `rsp_illegal`, returns `req_rd_old`, raises no strobe, does not halt and changes no register.
- R4: Address 0x2801 (group 5, index 1) holds the low half of the accumulator and 0x2802 holds the high half. Writing one half leaves the other half unchanged.
- R5: Shadow space starts at group 0 index 1024. The offset from 1024 divided by 32 is the bank and the offset modulo 32 is the register within it. Two banks are implemented, so the range is 0x0400 to 0x043F.
- R6: A read of an unimplemented address (such as 0x0005, 0x0012, 0x0440 or group 6) returns `req_rd_old`. A write there has no effect.
- R7: A write to 0x4000 (group 8, index 0) stores the value. If bit 4 (doze) or bit 5 (sleep) is set, the next cycle also pulses `pc_wr_en` with `pc_wr_val` equal to `cur_pc`+4 and sets `halt`, which stays set until reset.
- R8: A write to next-PC (0x0010) with a value other than `cur_pc` pulses `pc_wr_en` and `dslot_clr` with that value. A write equal to `cur_pc` pulses neither. A read of 0x0010 returns `cur_pc`.
- R9: The identification registers read their fixed values and ignore writes: 0x0000 gives 0x01000008, 0x0002 gives 0x00000020, 0x000A gives 0x01010000, 0x0080 gives the core number 0 and 0x0081 gives the core count 1.
- R10: A request presented at a clock edge gives `rsp_valid`, `rsp_rdata` and `rsp_illegal` after that edge, for one cycle. Any write returns `req_rd_old` as its data.
- R11: In supervisor mode a request to group 1, 2, 9 or 10 raises bit 0, 1, 2 or 3 of `ext_sel` in the request cycle, and a read returns `ext_rdata`.
- R12: The exception vector base (0x000B), exception PC (0x0020), exception address (0x0030) and exception status (0x0040) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | 16 | Group in bits 15:11, index in bits 10:0 |
| req_wdata | input | 32 | Write data |
| req_rd_old | input | 32 | Current value of the destination register |
| cur_pc | input | 32 | PC of the requesting instruction |
| ext_rdata | input | 32 | Read data from the selected external block |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read result |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| ext_sel | output | 4 | One-hot select for groups 1, 2, 9, 10 |
| pc_wr_en | output | 1 | PC load pulse |
| pc_wr_val | output | 32 | Value to load into the PC |
| dslot_clr | output | 1 | Clear the delay-slot flag |
| halt | output | 1 | Core halted |

## Verification
A corrupt privilege bit shows up on the very next response: a supervisor read flags `rsp_illegal`, or a user access is let through. A decode slip between neighbouring addresses, such as the two accumulator halves or adjacent shadow banks, appears on the first read back of the half or bank that was not written. Each such read returns its value one cycle after the request. Errors in the PC-load and halt paths appear in the cycle after the triggering write, and because `halt` never clears by itself, a wrong halt persists at the port.

// File: rtl/spr_unit.sv
module spr_unit #(
  parameter int          GRP_W        = 5,
  parameter int          IDX_W        = 11,
  parameter int          DW           = 32,
  parameter int          FPCSR_W      = 12,
  parameter int          SH_BANKS     = 2,
  parameter int          SH_REGS      = 32,
  parameter int          SH_BASE      = 1024,
  parameter int          DOZE_BIT     = 4,
  parameter int          SLEEP_BIT    = 5,
  parameter logic [31:0] ID_VERSION   = 32'h0100_0008,
  parameter logic [31:0] ID_UNITS     = 32'h0000_0001,
  parameter logic [31:0] ID_CPUCFG    = 32'h0000_0020,
  parameter logic [31:0] ID_DMMUCFG   = 32'h0000_0000,
  parameter logic [31:0] ID_IMMUCFG   = 32'h0000_0000,
  parameter logic [31:0] ID_VERSION2  = 32'h0100_0000,
  parameter logic [31:0] ID_ARCHVER   = 32'h0101_0000,
  parameter logic [31:0] CORE_NUM     = 32'h0000_0000,
  parameter logic [31:0] CORE_COUNT   = 32'h0000_0001
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [GRP_W+IDX_W-1:0] req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [DW-1:0]          req_rd_old,
  input  logic [DW-1:0]          cur_pc,
  input  logic [DW-1:0]          ext_rdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_illegal,
  output logic [3:0]             ext_sel,
  output logic                   pc_wr_en,
  output logic [DW-1:0]          pc_wr_val,
  output logic                   dslot_clr,
  output logic                   halt
);
  localparam int AW      = GRP_W + IDX_W;
  localparam int SH_WORDS = SH_BANKS * SH_REGS;
  localparam int BANK_W  = (SH_BANKS > 1) ? $clog2(SH_BANKS) : 1;
  localparam int REG_W   = $clog2(SH_REGS);

  function automatic logic [AW-1:0] mk(input int g, input int i);
    return {g[GRP_W-1:0], i[IDX_W-1:0]};
  endfunction

  localparam logic [AW-1:0] A_VER    = mk(0, 0);
  localparam logic [AW-1:0] A_UNITS  = mk(0, 1);
  localparam logic [AW-1:0] A_CPUCFG = mk(0, 2);
  localparam logic [AW-1:0] A_DMMU   = mk(0, 3);
  localparam logic [AW-1:0] A_IMMU   = mk(0, 4);
  localparam logic [AW-1:0] A_VER2   = mk(0, 9);
  localparam logic [AW-1:0] A_ARCH   = mk(0, 10);
  localparam logic [AW-1:0] A_VBASE  = mk(0, 11);
  localparam logic [AW-1:0] A_NPC    = mk(0, 16);
  localparam logic [AW-1:0] A_STAT   = mk(0, 17);
  localparam logic [AW-1:0] A_FPCSR  = mk(0, 20);
  localparam logic [AW-1:0] A_EPC    = mk(0, 32);
  localparam logic [AW-1:0] A_EADDR  = mk(0, 48);
  localparam logic [AW-1:0] A_ESTAT  = mk(0, 64);
  localparam logic [AW-1:0] A_COREN  = mk(0, 128);
  localparam logic [AW-1:0] A_CORES  = mk(0, 129);
  localparam logic [AW-1:0] A_ACCLO  = mk(5, 1);
  localparam logic [AW-1:0] A_ACCHI  = mk(5, 2);
  localparam logic [AW-1:0] A_PWR    = mk(8, 0);

  logic [FPCSR_W-1:0] fpcsr_q;
  logic [DW-1:0]      vbase_q, stat_q, epc_q, eaddr_q, estat_q, pwr_q;
  logic [2*DW-1:0]    acc_q;
  logic [DW-1:0]      shadow_q [SH_BANKS][SH_REGS];

  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx, sh_off;
  logic             sup, is_fp, illegal, wr_ok, hit_sh, ext_hit;
  logic [BANK_W-1:0] sh_bank;
  logic [REG_W-1:0]  sh_reg;
  logic [DW-1:0]     rd_mux;

  assign grp     = req_addr[AW-1:IDX_W];
  assign idx     = req_addr[IDX_W-1:0];
  assign sup     = stat_q[0];
  assign is_fp   = (req_addr == A_FPCSR);
  assign illegal = req_valid && !sup && !is_fp;
  assign wr_ok   = req_valid && req_write && !illegal;

  assign sh_off  = idx - IDX_W'(SH_BASE);
  assign hit_sh  = (grp == '0) && (idx >= IDX_W'(SH_BASE)) &&
                   (int'(sh_off) < SH_WORDS);
  assign sh_bank = BANK_W'(int'(sh_off) / SH_REGS);
  assign sh_reg  = REG_W'(int'(sh_off) % SH_REGS);

  assign ext_sel = (req_valid && sup) ?
                   {grp == GRP_W'(10), grp == GRP_W'(9), grp == GRP_W'(2), grp == GRP_W'(1)} :
                   4'b0000;
  assign ext_hit = |ext_sel;

  always_comb begin
    rd_mux = req_rd_old;
    if (hit_sh)
      rd_mux = shadow_q[sh_bank][sh_reg];
    else if (ext_hit)
      rd_mux = ext_rdata;
    else begin
      case (req_addr)
        A_VER:    rd_mux = ID_VERSION;
        A_UNITS:  rd_mux = ID_UNITS;
        A_CPUCFG: rd_mux = ID_CPUCFG;
        A_DMMU:   rd_mux = ID_DMMUCFG;
        A_IMMU:   rd_mux = ID_IMMUCFG;
        A_VER2:   rd_mux = ID_VERSION2;
        A_ARCH:   rd_mux = ID_ARCHVER;
        A_COREN:  rd_mux = CORE_NUM;
        A_CORES:  rd_mux = CORE_COUNT;
        A_VBASE:  rd_mux = vbase_q;
        A_NPC:    rd_mux = cur_pc;
        A_STAT:   rd_mux = stat_q;
        A_FPCSR:  rd_mux = DW'(fpcsr_q);
        A_EPC:    rd_mux = epc_q;
        A_EADDR:  rd_mux = eaddr_q;
        A_ESTAT:  rd_mux = estat_q;
        A_ACCLO:  rd_mux = acc_q[DW-1:0];
        A_ACCHI:  rd_mux = acc_q[2*DW-1:DW];
        A_PWR:    rd_mux = pwr_q;
        default:  rd_mux = req_rd_old;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= illegal;
      if (req_valid)
        rsp_rdata <= (illegal || req_write) ? req_rd_old : rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpcsr_q <= '0;
      vbase_q <= '0;
      stat_q  <= DW'(1);
      epc_q   <= '0;
      eaddr_q <= '0;
      estat_q <= '0;
      acc_q   <= '0;
      pwr_q   <= '0;
    end else if (wr_ok) begin
      case (req_addr)
        A_FPCSR: fpcsr_q <= req_wdata[FPCSR_W-1:0];
        A_VBASE: vbase_q <= req_wdata;
        A_STAT:  stat_q  <= req_wdata;
        A_EPC:   epc_q   <= req_wdata;
        A_EADDR: eaddr_q <= req_wdata;
        A_ESTAT: estat_q <= req_wdata;
        A_ACCLO: acc_q[DW-1:0]    <= req_wdata;
        A_ACCHI: acc_q[2*DW-1:DW] <= req_wdata;
        A_PWR:   pwr_q   <= req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < SH_BANKS; b++)
        for (int r = 0; r < SH_REGS; r++)
          shadow_q[b][r] <= '0;
    end else if (wr_ok && hit_sh) begin
      shadow_q[sh_bank][sh_reg] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_wr_en  <= 1'b0;
      pc_wr_val <= '0;
      dslot_clr <= 1'b0;
      halt      <= 1'b0;
    end else begin
      pc_wr_en  <= 1'b0;
      dslot_clr <= 1'b0;
      if (wr_ok && req_addr == A_NPC && req_wdata != cur_pc) begin
        pc_wr_en  <= 1'b1;
        pc_wr_val <= req_wdata;
        dslot_clr <= 1'b1;
      end
      if (wr_ok && req_addr == A_PWR && (req_wdata[DOZE_BIT] || req_wdata[SLEEP_BIT])) begin
        pc_wr_en  <= 1'b1;
        pc_wr_val <= cur_pc + DW'(4);
        halt      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spr_unit_sva.sv
module spr_unit_sva #(
  parameter int          AW      = 16,
  parameter logic [15:0] FP_ADDR = 16'h0014
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          sup,
  input logic          rsp_valid,
  input logic          rsp_illegal,
  input logic [3:0]    ext_sel,
  input logic          pc_wr_en,
  input logic          dslot_clr,
  input logic          halt
);
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r3_user_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sup && req_addr != AW'(FP_ADDR)) |=> rsp_illegal);
  a_r3_user_stays_user: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sup) |=> !sup);
  a_r3_no_user_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sup && !halt) |=> !halt);
  a_r2_fpcsr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == AW'(FP_ADDR)) |=> !rsp_illegal);
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  a_r8_dslot_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr |-> pc_wr_en);
  a_r11_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_sel));
  a_r11_no_user_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !sup |-> (ext_sel == 4'b0000));
endmodule

bind spr_unit spr_unit_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .sup        (stat_q[0]),
  .rsp_valid  (rsp_valid),
  .rsp_illegal(rsp_illegal),
  .ext_sel    (ext_sel),
  .pc_wr_en   (pc_wr_en),
  .dslot_clr  (dslot_clr),
  .halt       (halt)
);

// File: tb/spr_unit_tb_top.sv
module spr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0, req_rd_old = '0;
  logic [31:0] cur_pc = 32'h0000_2000;
  logic [31:0] ext_rdata = 32'h5EED_0001;
  logic        rsp_valid, rsp_illegal, pc_wr_en, dslot_clr, halt;
  logic [31:0] rsp_rdata, pc_wr_val;
  logic [3:0]  ext_sel;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  spr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rd_old(req_rd_old),
    .cur_pc(cur_pc), .ext_rdata(ext_rdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal), .ext_sel(ext_sel),
    .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val), .dslot_clr(dslot_clr), .halt(halt)
  );

  // {req#, write, addr, wdata, old, expected rdata, expected illegal}
  localparam int VW = 8 + 1 + 16 + 32 + 32 + 32 + 1;
  localparam int NV = 49;
  localparam logic [VW-1:0] VEC [NV] = '{
    // R1 reset values
    {8'd1, 1'b0, 16'h0011, 32'h0, 32'h5, 32'h0000_0001, 1'b0},
    {8'd1, 1'b0, 16'h000B, 32'h0, 32'h5, 32'h0, 1'b0},
    {8'd1, 1'b0, 16'h2801, 32'h0, 32'h5, 32'h0, 1'b0},
    {8'd1, 1'b0, 16'h4000, 32'h0, 32'h5, 32'h0, 1'b0},
    // R12 plain registers, R10 writes return old value
    {8'd10, 1'b1, 16'h000B, 32'hA5A5_0000, 32'h3, 32'h3, 1'b0},
    {8'd12, 1'b0, 16'h000B, 32'h0, 32'h7, 32'hA5A5_0000, 1'b0},
    {8'd12, 1'b1, 16'h0020, 32'h1111_0000, 32'h0, 32'h0, 1'b0},
    {8'd12, 1'b0, 16'h0020, 32'h0, 32'h0, 32'h1111_0000, 1'b0},
    {8'd12, 1'b1, 16'h0030, 32'h2222_3333, 32'h0, 32'h0, 1'b0},
    {8'd12, 1'b0, 16'h0030, 32'h0, 32'h0, 32'h2222_3333, 1'b0},
    {8'd12, 1'b1, 16'h0040, 32'h4444_5555, 32'h0, 32'h0, 1'b0},
    {8'd12, 1'b0, 16'h0040, 32'h0, 32'h0, 32'h4444_5555, 1'b0},
    // R4 accumulator halves
    {8'd4, 1'b1, 16'h2801, 32'hDEAD_BEEF, 32'h0, 32'h0, 1'b0},
    {8'd4, 1'b1, 16'h2802, 32'hCAFE_F00D, 32'h0, 32'h0, 1'b0},
    {8'd4, 1'b0, 16'h2801, 32'h0, 32'h0, 32'hDEAD_BEEF, 1'b0},
    {8'd4, 1'b0, 16'h2802, 32'h0, 32'h0, 32'hCAFE_F00D, 1'b0},
    {8'd4, 1'b1, 16'h2801, 32'h0123_4567, 32'h0, 32'h0, 1'b0},
    {8'd4, 1'b0, 16'h2802, 32'h0, 32'h0, 32'hCAFE_F00D, 1'b0},
    {8'd4, 1'b0, 16'h2801, 32'h0, 32'h0, 32'h0123_4567, 1'b0},
    {8'd4, 1'b1, 16'h2802, 32'h89AB_CDEF, 32'h0, 32'h0, 1'b0},
    {8'd4, 1'b0, 16'h2801, 32'h0, 32'h0, 32'h0123_4567, 1'b0},
    // R5 shadow banks
    {8'd5, 1'b1, 16'h0400, 32'h11, 32'h0, 32'h0, 1'b0},
    {8'd5, 1'b1, 16'h0421, 32'h22, 32'h0, 32'h0, 1'b0},
    {8'd5, 1'b1, 16'h043F, 32'h33, 32'h0, 32'h0, 1'b0},
    {8'd5, 1'b0, 16'h0401, 32'h0, 32'h9, 32'h0, 1'b0},
    {8'd5, 1'b0, 16'h0421, 32'h0, 32'h0, 32'h22, 1'b0},
    {8'd5, 1'b0, 16'h0400, 32'h0, 32'h0, 32'h11, 1'b0},
    {8'd5, 1'b0, 16'h043F, 32'h0, 32'h0, 32'h33, 1'b0},
    {8'd5, 1'b0, 16'h0420, 32'h0, 32'h9, 32'h0, 1'b0},
    // R6 unmapped
    {8'd6, 1'b0, 16'h0005, 32'h0, 32'h9999, 32'h9999, 1'b0},
    {8'd6, 1'b0, 16'h0440, 32'h0, 32'h1234, 32'h1234, 1'b0},
    {8'd6, 1'b1, 16'h0440, 32'h55, 32'h0, 32'h0, 1'b0},
    {8'd6, 1'b0, 16'h0440, 32'h0, 32'h77, 32'h77, 1'b0},
    {8'd6, 1'b0, 16'h3000, 32'h0, 32'hABCD, 32'hABCD, 1'b0},
    {8'd6, 1'b0, 16'h0012, 32'h0, 32'h3, 32'h3, 1'b0},
    // R2 floating-point control keeps 12 bits
    {8'd2, 1'b1, 16'h0014, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0},
    {8'd2, 1'b0, 16'h0014, 32'h0, 32'h0, 32'h0000_0FFF, 1'b0},
    // R9 identification
    {8'd9, 1'b0, 16'h0000, 32'h0, 32'h0, 32'h0100_0008, 1'b0},
    {8'd9, 1'b0, 16'h0002, 32'h0, 32'h0, 32'h0000_0020, 1'b0},
    {8'd9, 1'b0, 16'h000A, 32'h0, 32'h0, 32'h0101_0000, 1'b0},
    {8'd9, 1'b0, 16'h0080, 32'h0, 32'h6, 32'h0, 1'b0},
    {8'd9, 1'b0, 16'h0081, 32'h0, 32'h0, 32'h1, 1'b0},
    {8'd9, 1'b1, 16'h0000, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0},
    {8'd9, 1'b0, 16'h0000, 32'h0, 32'h0, 32'h0100_0008, 1'b0},
    // R11 external groups
    {8'd11, 1'b0, 16'h0A00, 32'h0, 32'h1, 32'h5EED_0001, 1'b0},
    {8'd11, 1'b0, 16'h1000, 32'h0, 32'h1, 32'h5EED_0001, 1'b0},
    {8'd11, 1'b0, 16'h4800, 32'h0, 32'h1, 32'h5EED_0001, 1'b0},
    {8'd11, 1'b0, 16'h5000, 32'h0, 32'h1, 32'h5EED_0001, 1'b0},
    // R8 next-PC read
    {8'd8, 1'b0, 16'h0010, 32'h0, 32'h0, 32'h0000_2000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [15:0] a, input logic [31:0] d,
                      input logic [31:0] o);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_rd_old = o;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R1 halt after reset", 32'(halt), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[VW-1 -: 8], i);
      xfer(v[VW-9], v[VW-10 -: 16], v[96:65], v[64:33]);
      chk({tg, " valid"}, 32'(rsp_valid), 32'h1);
      chk({tg, " rdata"}, rsp_rdata, v[32:1]);
      chk({tg, " illegal"}, 32'(rsp_illegal), 32'(v[0]));
    end

    // R10 single-cycle response
    @(negedge clk);
    chk("R10 rsp_valid drops", 32'(rsp_valid), 32'h0);

    // R11 strobe in request cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h4800; #1;
    chk("R11 ext_sel group9", 32'(ext_sel), 32'h4);
    req_addr = 16'h0800; #1;
    chk("R11 ext_sel group1", 32'(ext_sel), 32'h1);
    @(negedge clk); req_valid = 1'b0;

    // R8 next-PC writes
    xfer(1'b1, 16'h0010, 32'h0000_3000, 32'h0);
    chk("R8 pc_wr_en differ", 32'(pc_wr_en), 32'h1);
    chk("R8 pc_wr_val differ", pc_wr_val, 32'h0000_3000);
    chk("R8 dslot_clr differ", 32'(dslot_clr), 32'h1);
    xfer(1'b1, 16'h0010, 32'h0000_2000, 32'h0);
    chk("R8 pc_wr_en same", 32'(pc_wr_en), 32'h0);
    chk("R8 dslot_clr same", 32'(dslot_clr), 32'h0);

    // R7 power management
    xfer(1'b1, 16'h4000, 32'h0000_0001, 32'h0);
    chk("R7 no halt without doze/sleep", 32'(halt), 32'h0);
    chk("R7 no pc load without doze/sleep", 32'(pc_wr_en), 32'h0);
    xfer(1'b0, 16'h4000, 32'h0, 32'h0);
    chk("R7 power word stored", rsp_rdata, 32'h0000_0001);
    xfer(1'b1, 16'h4000, 32'h0000_0010, 32'h0);
    chk("R7 doze halts", 32'(halt), 32'h1);
    chk("R7 doze pc load", 32'(pc_wr_en), 32'h1);
    chk("R7 doze pc value", pc_wr_val, 32'h0000_2004);
    @(negedge clk);
    chk("R7 halt holds", 32'(halt), 32'h1);
    do_reset();
    chk("R1 halt cleared by reset", 32'(halt), 32'h0);
    xfer(1'b1, 16'h4000, 32'h0000_0020, 32'h0);
    chk("R7 sleep halts", 32'(halt), 32'h1);
    do_reset();

    // R3 user mode
    xfer(1'b1, 16'h0011, 32'h0, 32'h0);
    chk("R3 status write legal in supervisor", 32'(rsp_illegal), 32'h0);
    xfer(1'b1, 16'h0014, 32'h0000_0005, 32'h0);
    chk("R2 user fpcsr write legal", 32'(rsp_illegal), 32'h0);
    xfer(1'b0, 16'h0014, 32'h0, 32'h0);
    chk("R2 user fpcsr read", rsp_rdata, 32'h0000_0005);
    chk("R2 user fpcsr read legal", 32'(rsp_illegal), 32'h0);
    xfer(1'b1, 16'h000B, 32'h77, 32'h0);
    chk("R3 user write illegal", 32'(rsp_illegal), 32'h1);
    xfer(1'b0, 16'h000B, 32'h0, 32'h42);
    chk("R3 user read illegal", 32'(rsp_illegal), 32'h1);
    chk("R3 user read returns old", rsp_rdata, 32'h42);
    xfer(1'b1, 16'h0011, 32'h1, 32'h0);
    xfer(1'b0, 16'h0011, 32'h0, 32'h0);
    chk("R3 status unchanged by user write", 32'(rsp_illegal), 32'h1);
    xfer(1'b1, 16'h4000, 32'h0000_0030, 32'h0);
    chk("R3 no user halt", 32'(halt), 32'h0);
    chk("R3 no user pc load", 32'(pc_wr_en), 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h4800; #1;
    chk("R3 no user strobe", 32'(ext_sel), 32'h0);
    @(negedge clk); req_valid = 1'b0;

    finish_run();
  end
endmodule